// File: doc/BRIEF.md
# Buzzer and Clock Output Generator

This block drives a four-bit output pin group from a four-bit output register. Three of the pins can take a special function instead of plain DC. Pin 0 carries a buzzer square wave. Pin 3 carries the complement of that wave, so the two pins together drive a piezo sounder differentially. Pin 2 carries the oscillator clock divided by a power of two that a parameter fixes. Pin 1 is always plain DC. When a special function is enabled, its register bit gates the waveform, and the pin sits low while the bit is 0. When a special function is disabled by parameter, the pin simply follows its register bit.

The buzzer pitch comes from a separate pitch register. The buzzer and clock waveforms are taps of one free-running prescaler. At a 32.768 kHz oscillator, the fast tap at fosc/8 gives 4 kHz and the slow tap at fosc/16 gives 2 kHz. An enable, a disable or a pitch change takes effect only while the affected waveform is low. As a result, no truncated pulse ever reaches a pin. Software reads both registers back through a registered read port.

Top module: `tone_clkout_gen`

## Requirements
- R1: After reset all four pins are low, the output register reads 0000 and the pitch register reads 0000, which selects the fast pitch.
- R2: Pin 1 follows output register bit 1. It shows a written value two clock edges after the write is sampled.
- R3: With output register bit 0 at 1 and the pitch bit at 0, pin 0 toggles with high and low phases of 2^FAST_BIT clocks each (4 cycles by default, fosc/8).
- R4: Pitch register bit 3 set to 1 doubles the buzzer half period to 2^(FAST_BIT+1) clocks (fosc/16). Bits 2..0 of the pitch register are not stored.
- R5: While the buzzer runs, pin 3 is the exact complement of pin 0. Under the default gating choice, output register bit 0 gates pin 3 and bit 3 has no effect on pin 3.
- R6: With output register bit 0 at 0, pins 0 and 3 both settle low and stay low.
- R7: With output register bit 2 at 1, pin 2 is the clock divided by 2^CK_DIV_LOG2 (high and low phases of 2 clocks by default). With bit 2 at 0, pin 2 is low.
- R8: Every high pulse on pins 0, 2 and 3 lasts a full half period of its source, and every low phase lasts at least the fast half period. This holds for any timing of enable writes and pitch writes.
- R9: The read port returns the selected register one clock after the select is presented. Select 0 returns the output register. Select 1 returns the pitch flag in bit 3, with bits 2..0 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 output register, 1 pitch register |
| wr_data_i | input | 4 | Write data |
| rd_sel_i | input | 1 | Read target: 0 output register, 1 pitch register |
| rd_data_o | output | 4 | Registered read data |
| pins_o | output | 4 | Output pins: 0 buzzer, 1 DC, 2 clock out, 3 inverted buzzer |

## Verification
The hardest situation to reach is a write that lands in the middle of a high phase or on the last cycle of a low phase, where a careless gate would emit a runt. Several clean pulses are not enough to rule this out. The bench therefore issues strings of enable toggles and pitch toggles spaced by gaps that vary from one to several cycles, so that the writes walk across every prescaler phase. Meanwhile, parallel monitors record the length of every completed high and low run on both buzzer pins and flag any run that is not a legal half period.

// File: rtl/tcg_pkg.sv
package tcg_pkg;
  localparam int PIN_W     = 4;
  localparam int PIN_BZ    = 0;
  localparam int PIN_DC    = 1;
  localparam int PIN_CK    = 2;
  localparam int PIN_BZN   = 3;
  localparam int PITCH_BIT = 3;

  typedef enum logic {
    SEL_OUTREG = 1'b0,
    SEL_PITCH  = 1'b1
  } tcg_sel_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tcg_prescaler.sv
module tcg_prescaler #(
  parameter int FAST_BIT = 2,
  parameter int CK_TAP   = 1
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic tap_fast_o,
  output logic tap_slow_o,
  output logic tap_ck_o
);
  localparam int W = tcg_pkg::imax(FAST_BIT + 2, CK_TAP + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= '0;
    else       cnt_q <= cnt_q + 1'b1;
  end

  assign tap_fast_o = cnt_q[FAST_BIT];
  assign tap_slow_o = cnt_q[FAST_BIT+1];

  generate
    if (CK_TAP >= 0) begin : g_tap
      assign tap_ck_o = cnt_q[CK_TAP];
    end else begin : g_notap
      assign tap_ck_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tcg_pitch_mux.sv
module tcg_pitch_mux (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tap_fast_i,
  input  logic tap_slow_i,
  input  logic slow_req_i,
  output logic wave_o
);
  logic slow_act_q;

  // Handover only while both taps are low, so the selected wave is low on
  // both sides of the switch.
  always_ff @(posedge clk_i) begin
    if (rst_i)                           slow_act_q <= 1'b0;
    else if (!tap_fast_i && !tap_slow_i) slow_act_q <= slow_req_i;
  end

  assign wave_o = slow_act_q ? tap_slow_i : tap_fast_i;
endmodule

// File: rtl/tcg_safe_gate.sv
module tcg_safe_gate (
  input  logic clk_i,
  input  logic rst_i,
  input  logic req_i,
  input  logic wave_i,
  output logic pin_o
);
  logic act_q;

  // The enable is only sampled while the wave is low, so a running high
  // phase always completes and a new one always starts from its edge.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      act_q <= 1'b0;
      pin_o <= 1'b0;
    end else begin
      if (!wave_i) act_q <= req_i;
      pin_o <= act_q & wave_i;
    end
  end
endmodule

// File: rtl/tcg_regs.sv
module tcg_regs (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       wr_en_i,
  input  logic       wr_sel_i,
  input  logic [3:0] wr_data_i,
  output logic [3:0] out_reg_o,
  output logic       slow_o
);
  import tcg_pkg::*;

  tcg_sel_e sel;
  assign sel = tcg_sel_e'(wr_sel_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      out_reg_o <= '0;
      slow_o    <= 1'b0;
    end else if (wr_en_i) begin
      if (sel == SEL_PITCH) slow_o    <= wr_data_i[PITCH_BIT];
      else                  out_reg_o <= wr_data_i;
    end
  end
endmodule

// File: rtl/tone_clkout_gen.sv
module tone_clkout_gen #(
  parameter int FAST_BIT    = 2,
  parameter bit BZ_ON       = 1'b1,
  parameter bit INV_ON      = 1'b1,
  parameter bit INV_FROM_R3 = 1'b0,
  parameter bit CK_ON       = 1'b1,
  parameter int CK_DIV_LOG2 = 2
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       wr_en_i,
  input  logic       wr_sel_i,
  input  logic [3:0] wr_data_i,
  input  logic       rd_sel_i,
  output logic [3:0] rd_data_o,
  output logic [3:0] pins_o
);
  import tcg_pkg::*;

  localparam int CK_TAP   = CK_DIV_LOG2 - 1;
  localparam bit BZN_LIVE = BZ_ON && INV_ON;

  logic [PIN_W-1:0] out_reg;
  logic             slow_sel;
  logic             tap_fast, tap_slow, tap_ck;
  logic             wave_bz;
  logic             p_bz, p_dc, p_ck, p_bzn;
  tcg_sel_e         rsel;

  tcg_regs u_regs (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .out_reg_o (out_reg),
    .slow_o    (slow_sel)
  );

  tcg_prescaler #(.FAST_BIT(FAST_BIT), .CK_TAP(CK_TAP)) u_pre (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .tap_fast_o (tap_fast),
    .tap_slow_o (tap_slow),
    .tap_ck_o   (tap_ck)
  );

  tcg_pitch_mux u_pitch (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .tap_fast_i (tap_fast),
    .tap_slow_i (tap_slow),
    .slow_req_i (slow_sel),
    .wave_o     (wave_bz)
  );

  // Read path
  assign rsel = tcg_sel_e'(rd_sel_i);
  always_ff @(posedge clk_i) begin
    if (rst_i)                  rd_data_o <= '0;
    else if (rsel == SEL_PITCH) rd_data_o <= {slow_sel, 3'b000};
    else                        rd_data_o <= out_reg;
  end

  // Pin 1: plain DC
  always_ff @(posedge clk_i) begin
    if (rst_i) p_dc <= 1'b0;
    else       p_dc <= out_reg[PIN_DC];
  end

  // Pin 0: buzzer or DC
  generate
    if (BZ_ON) begin : g_bz
      tcg_safe_gate u_gate (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .req_i  (out_reg[PIN_BZ]),
        .wave_i (wave_bz),
        .pin_o  (p_bz)
      );
    end else begin : g_bz_dc
      always_ff @(posedge clk_i) begin
        if (rst_i) p_bz <= 1'b0;
        else       p_bz <= out_reg[PIN_BZ];
      end
    end
  endgenerate

  // Pin 3: inverted buzzer or DC
  generate
    if (BZN_LIVE) begin : g_bzn
      logic bzn_req;
      assign bzn_req = INV_FROM_R3 ? out_reg[PIN_BZN] : out_reg[PIN_BZ];
      tcg_safe_gate u_gate (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .req_i  (bzn_req),
        .wave_i (~wave_bz),
        .pin_o  (p_bzn)
      );
    end else begin : g_bzn_dc
      always_ff @(posedge clk_i) begin
        if (rst_i) p_bzn <= 1'b0;
        else       p_bzn <= out_reg[PIN_BZN];
      end
    end
  endgenerate

  // Pin 2: divided clock or DC
  generate
    if (CK_ON && CK_DIV_LOG2 > 0) begin : g_ck
      tcg_safe_gate u_gate (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .req_i  (out_reg[PIN_CK]),
        .wave_i (tap_ck),
        .pin_o  (p_ck)
      );
    end else if (CK_ON) begin : g_ck_full
      logic en_low_q;
      // Enable changes only while the clock is low.
      always_ff @(negedge clk_i) begin
        if (rst_i) en_low_q <= 1'b0;
        else       en_low_q <= out_reg[PIN_CK];
      end
      assign p_ck = clk_i & en_low_q;
    end else begin : g_ck_dc
      always_ff @(posedge clk_i) begin
        if (rst_i) p_ck <= 1'b0;
        else       p_ck <= out_reg[PIN_CK];
      end
    end
  endgenerate

  assign pins_o = {p_bzn, p_ck, p_dc, p_bz};
endmodule

// File: rtl/tcg_chk.sv
module tcg_chk #(
  parameter int FAST_BIT = 2,
  parameter bit BZ_LIVE  = 1'b1,
  parameter bit BZN_LIVE = 1'b1,
  parameter int CK_HALF  = 2
) (
  input logic       clk_i,
  input logic       rst_i,
  input logic       wr_en_i,
  input logic       wr_sel_i,
  input logic       wr_d1_i,
  input logic       rd_sel_i,
  input logic [2:0] rd_data_i,
  input logic [3:0] pins_i
);
  localparam int HF = 1 << FAST_BIT;
  localparam int HS = 2 * HF;

  logic [15:0] run0, run2, run3;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run0 <= '0;
      run2 <= '0;
      run3 <= '0;
    end else begin
      run0 <= pins_i[0] ? ((run0 != 16'hFFFF) ? run0 + 16'd1 : run0) : 16'd0;
      run2 <= pins_i[2] ? ((run2 != 16'hFFFF) ? run2 + 16'd1 : run2) : 16'd0;
      run3 <= pins_i[3] ? ((run3 != 16'hFFFF) ? run3 + 16'd1 : run3) : 16'd0;
    end
  end

  // R2
  dc_pin_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && !wr_sel_i) |=> ##1 (pins_i[1] == $past(wr_d1_i, 2)));

  // R9
  pitch_read_pad_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_sel_i |=> (rd_data_i == 3'b000));

  generate
    if (BZ_LIVE) begin : g_a_bz
      // R8
      bz_full_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(pins_i[0]) |-> (run0 == 16'(HF) || run0 == 16'(HS)));
    end
    if (BZN_LIVE) begin : g_a_bzn
      // R5
      pair_exclusive_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(pins_i[0] && pins_i[3]));
      // R8
      bzn_full_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(pins_i[3]) |-> (run3 == 16'(HF) || run3 == 16'(HS)));
    end
    if (CK_HALF > 0) begin : g_a_ck
      // R7
      ck_half_period_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(pins_i[2]) |-> (run2 == 16'(CK_HALF)));
    end
  endgenerate
endmodule

bind tone_clkout_gen tcg_chk #(
  .FAST_BIT (FAST_BIT),
  .BZ_LIVE  (BZ_ON),
  .BZN_LIVE (BZ_ON && INV_ON),
  .CK_HALF  ((CK_ON && CK_DIV_LOG2 > 0) ? (1 << (CK_DIV_LOG2 - 1)) : 0)
) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_d1_i   (wr_data_i[1]),
  .rd_sel_i  (rd_sel_i),
  .rd_data_i (rd_data_o[2:0]),
  .pins_i    (pins_o)
);

// File: tb/sim_tone_clkout_gen.sv
module sim_tone_clkout_gen;
  localparam int FAST_BIT = 2;
  localparam int CK_DIV   = 2;
  localparam int HF = 1 << FAST_BIT;
  localparam int HS = 2 * HF;
  localparam int HC = 1 << (CK_DIV - 1);

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [3:0] wr_data = '0;
  logic       rd_sel = 1'b0;
  logic [3:0] rd_data;
  logic [3:0] pins;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tone_clkout_gen #(.FAST_BIT(FAST_BIT), .CK_DIV_LOG2(CK_DIV)) u0 (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data), .pins_o(pins)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [3:0] v);
    @(negedge clk);
    rd_sel = s;
    @(negedge clk);
    v = rd_data;
  endtask

  // Run-length monitor over n samples; first and last runs are discarded.
  task automatic measure(input int idx, input int n, input int ok_a, input int ok_b,
                         output int hmin, output int hmax, output int lmin,
                         output int lmax, output int nodd);
    logic cur, v;
    int run;
    bit started;
    hmin = 9999; hmax = 0; lmin = 9999; lmax = 0; nodd = 0;
    @(negedge clk);
    cur = pins[idx]; run = 1; started = 0;
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      v = pins[idx];
      if (v == cur) run++;
      else begin
        if (started) begin
          if (cur) begin
            if (run < hmin) hmin = run;
            if (run > hmax) hmax = run;
            if (run != ok_a && run != ok_b) nodd++;
          end else begin
            if (run < lmin) lmin = run;
            if (run > lmax) lmax = run;
          end
        end
        started = 1; cur = v; run = 1;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] v;
    int hmin, hmax, lmin, lmax, nodd;
    int hmin3, hmax3, lmin3, lmax3, nodd3;
    int errs;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(pins == 4'b0000, "R1 pins after reset", pins, 0);
    rd(1'b0, v); chk(v == 4'b0000, "R1 output register reset", v, 0);
    rd(1'b1, v); chk(v == 4'b0000, "R1 pitch register reset", v, 0);

    // R2 DC pin
    wr(1'b0, 4'b0010);
    @(negedge clk); @(negedge clk);
    chk(pins == 4'b0010, "R2 DC pin follows bit 1", pins, 2);
    rd(1'b0, v); chk(v == 4'b0010, "R9 output register readback", v, 2);

    // R5 bit 3 does not gate pin 3 under default choice
    wr(1'b0, 4'b1010);
    errs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pins[3] || !pins[1]) errs++;
    end
    chk(errs == 0, "R5 bit 3 ignored for pin 3", errs, 0);

    // R4/R9 pitch bits below bit 3 not stored
    wr(1'b1, 4'b0111);
    rd(1'b1, v); chk(v == 4'b0000, "R9 pitch low bits read 0", v, 0);
    rd(1'b0, v); chk(v == 4'b1010, "R4 pitch write leaves output register", v, 10);

    // R3 fast pitch
    wr(1'b0, 4'b0001);
    repeat (40) @(negedge clk);
    measure(0, 64, HF, HF, hmin, hmax, lmin, lmax, nodd);
    chk(hmin == HF && hmax == HF && nodd == 0, "R3 fast high phase", hmax, HF);
    chk(lmin == HF && lmax == HF, "R3 fast low phase", lmax, HF);
    errs = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (pins[3] == pins[0]) errs++;
    end
    chk(errs == 0, "R5 pin 3 complements pin 0", errs, 0);

    // R4 slow pitch
    wr(1'b1, 4'b1000);
    rd(1'b1, v); chk(v == 4'b1000, "R9 pitch readback", v, 8);
    repeat (40) @(negedge clk);
    measure(0, 96, HS, HS, hmin, hmax, lmin, lmax, nodd);
    chk(hmin == HS && hmax == HS && nodd == 0, "R4 slow high phase", hmax, HS);
    chk(lmin == HS && lmax == HS, "R4 slow low phase", lmax, HS);
    wr(1'b1, 4'b0000);

    // R6 disable
    wr(1'b0, 4'b0000);
    repeat (20) @(negedge clk);
    errs = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (pins != 4'b0000) errs++;
    end
    chk(errs == 0, "R6 buzzer pins low when disabled", errs, 0);

    // R7 clock out
    wr(1'b0, 4'b0100);
    repeat (20) @(negedge clk);
    measure(2, 64, HC, HC, hmin, hmax, lmin, lmax, nodd);
    chk(hmin == HC && hmax == HC, "R7 clock out high phase", hmax, HC);
    chk(lmin == HC && lmax == HC, "R7 clock out low phase", lmax, HC);
    chk(pins[0] == 1'b0 && pins[3] == 1'b0, "R6 buzzer off with clock out", pins, 4);
    wr(1'b0, 4'b0000);
    repeat (10) @(negedge clk);
    chk(pins[2] == 1'b0, "R7 clock out low when disabled", pins[2], 0);

    // R8 enable toggles at every phase
    fork
      measure(0, 600, HF, HF, hmin, hmax, lmin, lmax, nodd);
      measure(3, 600, HF, HF, hmin3, hmax3, lmin3, lmax3, nodd3);
      begin
        for (int k = 0; k < 30; k++) begin
          wr(1'b0, {3'b000, k[0]});
          repeat (k % 5 + 1) @(negedge clk);
        end
      end
    join
    chk(nodd == 0 && hmin == HF && lmin >= HF, "R8 pin 0 no runt on enable", nodd, 0);
    chk(nodd3 == 0 && hmin3 == HF && lmin3 >= HF, "R8 pin 3 no runt on enable", nodd3, 0);

    // R8 pitch toggles at every phase while running
    wr(1'b0, 4'b0001);
    fork
      measure(0, 900, HF, HS, hmin, hmax, lmin, lmax, nodd);
      measure(3, 900, HF, HS, hmin3, hmax3, lmin3, lmax3, nodd3);
      begin
        for (int k = 0; k < 40; k++) begin
          wr(1'b1, {k[0], 3'b000});
          repeat (k % 7 + 1) @(negedge clk);
        end
      end
    join
    chk(nodd == 0 && hmin >= HF && lmin >= HF, "R8 pin 0 no runt on pitch change", nodd, 0);
    chk(nodd3 == 0 && hmin3 >= HF && lmin3 >= HF, "R8 pin 3 no runt on pitch change", nodd3, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule